// File: doc/BRIEF.md
# Character log line assembler

This block gathers a stream of text characters, one byte per accepted transfer, into an internal line store. Each byte that is neither a newline nor arrives at a full store is written at the current fill position and the fill position advances. A newline, or a byte that arrives when the store is one slot short of full, closes the line: a zero byte is written at the fill position as terminator, the fill position returns to zero, and the line is handed downstream.

The finished line is read out in order, from position zero up to and including the zero terminator, one byte per cycle under a valid/ready handshake. While a line is being read out the input side is held off, so no new characters enter until the last byte of the line has been taken. What happens to the line further downstream is outside this block.

Top module: `log_line_assembler`

## Requirements
- R1: After reset `in_ready` is 1, `out_valid` is 0 and the fill position is 0; memory contents are not cleared.
- R2: An accepted byte other than 0x0A, arriving while the fill position is below DEPTH-1, is stored at the fill position and the fill position increases by one; a 0x00 input byte is stored like any other character.
- R3: An accepted 0x0A byte is never stored; it closes the line, and from the next cycle the stored characters are offered on `out_data` in arrival order.
- R4: When the fill position equals DEPTH-1 (DEPTH defaults to 4096, one slot kept for the terminator), the next accepted byte closes the line whatever its value and is itself dropped, so the line holds DEPTH-1 characters.
- R5: Every emitted line ends with a byte 0x00 on which `out_last` is 1; `out_last` is 0 on every other byte; a newline at fill position 0 emits a line that is only this terminator.
- R6: While `out_valid` is 1 and `out_ready` is 0, `out_data` and `out_last` hold; each cycle with both high advances by exactly one byte.
- R7: While a line is being read out `in_ready` is 0 and `out_valid` is 1; bytes offered then are not taken and do not appear in any line.
- R8: After the terminator is taken, `in_ready` returns to 1 on the next cycle and the next line starts at fill position 0.
- R9: Reset in the middle of a line or of a read-out discards it; the next line contains only characters accepted after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | A character is offered |
| in_data | input | CHAR_W | Offered character |
| in_ready | output | 1 | The block takes the offered character this cycle |
| out_valid | output | 1 | A line byte is offered downstream |
| out_data | output | CHAR_W | Current line byte |
| out_last | output | 1 | Current byte is the zero terminator |
| out_ready | input | 1 | Downstream takes the current line byte |

## Verification
The bench goes after the full-store boundary with a small DEPTH: a design that kept the triggering byte, or flushed one slot early or late, would emit a line one character too long or too short, or lose the terminator. Empty lines and zero-valued characters are sent, where a design keying the end of line on a zero byte would cut the line short. Characters are offered throughout every read-out with a stalling consumer, so a design that let input leak in during drain, or advanced its read pointer without a handshake, would corrupt or repeat bytes. Reset is applied both mid-line and mid-drain, where a design keeping its fill position would prepend stale characters.

// File: rtl/alc_pkg.sv
package alc_pkg;
   typedef enum logic {
      ALC_FILL  = 1'b0,
      ALC_DRAIN = 1'b1
   } alc_mode_e;

   localparam logic [7:0] ALC_NEWLINE = 8'h0A;
endpackage

// File: rtl/alc_line_mem.sv
module alc_line_mem #(
   parameter int DEPTH  = 4096,
   parameter int CHAR_W = 8,
   localparam int AW    = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              wr_en,
   input  logic [AW-1:0]     wr_addr,
   input  logic [CHAR_W-1:0] wr_data,
   input  logic [AW-1:0]     rd_addr,
   output logic [CHAR_W-1:0] rd_data
);
   logic [CHAR_W-1:0] store [DEPTH];

   always_ff @(posedge clk) begin
      if (wr_en) store[wr_addr] <= wr_data;
   end

   generate
      if ((1 << AW) == DEPTH) begin : g_pow2
         assign rd_data = store[rd_addr];
      end else begin : g_npow2
         assign rd_data = (32'(rd_addr) < DEPTH) ? store[rd_addr] : '0;
      end
   endgenerate
endmodule

// File: rtl/alc_fill_ctrl.sv
module alc_fill_ctrl
   import alc_pkg::*;
#(
   parameter int DEPTH  = 4096,
   parameter int CHAR_W = 8,
   localparam int AW    = $clog2(DEPTH),
   localparam logic [AW-1:0] LAST = AW'(DEPTH - 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [CHAR_W-1:0] in_data,
   input  logic              drain_done,
   output logic              in_ready,
   output logic              wr_en,
   output logic [AW-1:0]     wr_addr,
   output logic [CHAR_W-1:0] wr_data,
   output logic              flush,
   output logic [AW-1:0]     line_len
);
   alc_mode_e   mode;
   logic [AW-1:0] fill;
   logic        take;
   logic        is_nl;

   assign in_ready = (mode == ALC_FILL);
   assign take     = in_valid && in_ready;
   assign is_nl    = (in_data == CHAR_W'(ALC_NEWLINE));
   assign flush    = take && (is_nl || fill == LAST);
   assign wr_en    = take;
   assign wr_addr  = fill;
   assign wr_data  = flush ? '0 : in_data;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode     <= ALC_FILL;
         fill     <= '0;
         line_len <= '0;
      end else if (flush) begin
         mode     <= ALC_DRAIN;
         line_len <= fill;
         fill     <= '0;
      end else if (take) begin
         fill     <= fill + AW'(1);
      end else if (mode == ALC_DRAIN && drain_done) begin
         mode     <= ALC_FILL;
      end
   end

   AST_FILL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      fill <= LAST);                                                    // R4
   AST_NL_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
      (take && is_nl) |=> (!in_ready && fill == '0));                   // R3
   AST_FULL_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
      (take && fill == LAST) |=> (!in_ready && fill == '0));            // R4
   AST_STORE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (take && !is_nl && fill != LAST) |=> (fill == $past(fill) + AW'(1))); // R2
endmodule

// File: rtl/alc_reader.sv
module alc_reader #(
   parameter int DEPTH = 4096,
   localparam int AW   = $clog2(DEPTH)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic [AW-1:0] len,
   input  logic          out_ready,
   output logic          out_valid,
   output logic          out_last,
   output logic [AW-1:0] rd_addr,
   output logic          done
);
   logic          active;
   logic [AW-1:0] ptr;

   assign out_valid = active;
   assign out_last  = active && (ptr == len);
   assign rd_addr   = ptr;
   assign done      = out_valid && out_ready && out_last;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active <= 1'b0;
         ptr    <= '0;
      end else if (start) begin
         active <= 1'b1;
         ptr    <= '0;
      end else if (done) begin
         active <= 1'b0;
         ptr    <= '0;
      end else if (out_valid && out_ready) begin
         ptr    <= ptr + AW'(1);
      end
   end

   AST_PTR_IN_LINE: assert property (@(posedge clk) disable iff (!rst_n)
      active |-> (ptr <= len));                                         // R5
   AST_END_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !out_valid);                                             // R8
endmodule

// File: rtl/log_line_assembler.sv
module log_line_assembler #(
   parameter int DEPTH  = 4096,
   parameter int CHAR_W = 8,
   localparam int AW    = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [CHAR_W-1:0] in_data,
   output logic              in_ready,
   output logic              out_valid,
   output logic [CHAR_W-1:0] out_data,
   output logic              out_last,
   input  logic              out_ready
);
   generate
      if (DEPTH < 2) begin : g_bad_depth
         $error("log_line_assembler: DEPTH must be at least 2");
      end
      if (CHAR_W < 7) begin : g_bad_width
         $error("log_line_assembler: CHAR_W must hold a newline code");
      end
   endgenerate

   logic              wr_en;
   logic [AW-1:0]     wr_addr;
   logic [CHAR_W-1:0] wr_data;
   logic [AW-1:0]     rd_addr;
   logic              flush;
   logic [AW-1:0]     line_len;
   logic              drain_done;

   alc_fill_ctrl #(.DEPTH(DEPTH), .CHAR_W(CHAR_W)) u_fill (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_valid  (in_valid),
      .in_data   (in_data),
      .drain_done(drain_done),
      .in_ready  (in_ready),
      .wr_en     (wr_en),
      .wr_addr   (wr_addr),
      .wr_data   (wr_data),
      .flush     (flush),
      .line_len  (line_len)
   );

   alc_line_mem #(.DEPTH(DEPTH), .CHAR_W(CHAR_W)) u_mem (
      .clk    (clk),
      .wr_en  (wr_en),
      .wr_addr(wr_addr),
      .wr_data(wr_data),
      .rd_addr(rd_addr),
      .rd_data(out_data)
   );

   alc_reader #(.DEPTH(DEPTH)) u_rd (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (flush),
      .len      (line_len),
      .out_ready(out_ready),
      .out_valid(out_valid),
      .out_last (out_last),
      .rd_addr  (rd_addr),
      .done     (drain_done)
   );

   AST_TERM_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_last) |-> (out_data == '0));                    // R5
   AST_HOLD_STALL: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_last))); // R6
   AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> !in_ready);                                         // R7
   AST_FLUSH_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> out_valid);                                             // R3
endmodule

// File: tb/log_line_assembler_test.sv
`timescale 1ns/1ps
module log_line_assembler_test;
   localparam int D = 16;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       in_valid = 1'b0;
   logic [7:0] in_data = 8'h00;
   logic       out_ready = 1'b0;
   logic       in_ready, out_valid, out_last;
   logic [7:0] out_data;

   always #2.5 clk = ~clk;

   log_line_assembler #(.DEPTH(D), .CHAR_W(8)) uut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
      .in_ready(in_ready), .out_valid(out_valid), .out_data(out_data),
      .out_last(out_last), .out_ready(out_ready)
   );

   int    n_cmp = 0;
   int    n_bad = 0;
   string tag   = "R1";

   bit          m_drain = 0;
   byte unsigned m_cur[$];
   byte unsigned m_line[$];
   int          m_idx = 0;

   task automatic report(string f, int act, int exp);
      $display("FAIL %s %s actual %02h expected %02h", tag, f, act, exp);
   endtask

   task automatic compare();
      bit bad = 0;
      n_cmp++;
      if (in_ready !== !m_drain) begin report("in_ready", in_ready, !m_drain); bad = 1; end
      if (out_valid !== m_drain) begin report("out_valid", out_valid, m_drain); bad = 1; end
      if (m_drain) begin
         if (out_data !== m_line[m_idx]) begin report("out_data", out_data, m_line[m_idx]); bad = 1; end
         if (out_last !== (m_idx == m_line.size() - 1)) begin
            report("out_last", out_last, (m_idx == m_line.size() - 1)); bad = 1;
         end
      end
      if (bad) n_bad++;
   endtask

   task automatic model_next(bit v, byte unsigned d, bit r);
      if (!rst_n) return;
      if (!m_drain) begin
         if (v) begin
            if (d == 8'h0A || m_cur.size() == D - 1) begin
               m_line = m_cur;
               m_line.push_back(8'h00);
               m_cur = {};
               m_idx = 0;
               m_drain = 1;
            end else begin
               m_cur.push_back(d);
            end
         end
      end else if (r) begin
         if (m_idx == m_line.size() - 1) m_drain = 0;
         else m_idx++;
      end
   endtask

   task automatic step(bit v, byte unsigned d, bit r);
      @(negedge clk);
      compare();
      in_valid = v; in_data = d; out_ready = r;
      model_next(v, d, r);
   endtask

   task automatic send(byte unsigned d, bit rand_ready);
      bit acc;
      do begin
         acc = !m_drain;
         step(1'b1, d, rand_ready ? 1'($urandom % 2) : 1'b1);
      end while (!acc);
   endtask

   task automatic drain(bit rand_ready, bit noise);
      while (m_drain)
         step(noise, 8'h41, rand_ready ? 1'($urandom % 2) : 1'b1);
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0; in_valid = 1'b0; out_ready = 1'b0;
      m_drain = 0; m_cur = {}; m_line = {}; m_idx = 0;
      step(0, 0, 0);
      step(0, 0, 0);
      rst_n = 1'b1;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog expired actual 1 expected 0");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      // R1: reset state
      tag = "R1";
      m_drain = 0;
      step(0, 0, 0);
      step(0, 0, 0);
      rst_n = 1'b1;
      repeat (3) step(0, 0, 1);

      // R2 / R3: ordinary characters including a zero byte, then newline
      tag = "R2";
      send(8'h48, 0); send(8'h69, 0); send(8'h00, 0); send(8'h21, 0);
      tag = "R3";
      send(8'h0A, 0);
      drain(0, 0);
      step(0, 0, 1);

      // R5: empty line gives only the terminator
      tag = "R5";
      send(8'h0A, 0);
      drain(0, 0);

      // R4: store one short of full, the next byte flushes and is dropped
      tag = "R4";
      for (int i = 0; i < D - 1; i++) send(8'h30 + 8'(i), 0);
      send(8'h5A, 0);
      drain(0, 0);
      for (int i = 0; i < D - 1; i++) send(8'h61 + 8'(i), 0);
      send(8'h0A, 0);
      drain(0, 0);

      // R6 / R7: stalling consumer with characters offered during drain
      tag = "R6";
      send(8'h31, 0); send(8'h32, 0); send(8'h33, 0); send(8'h0A, 0);
      tag = "R7";
      drain(1, 1);

      // R8: random stream, back-to-back lines across the full boundary
      tag = "R8";
      for (int i = 0; i < 300; i++) begin
         byte unsigned b = 8'($urandom % 20 == 0 ? 8'h0A : $urandom);
         send(b, 1);
      end
      drain(1, 1);

      // R9: reset mid-line then mid-drain
      tag = "R9";
      send(8'h71, 0); send(8'h72, 0); send(8'h73, 0);
      do_reset();
      send(8'h0A, 0);
      drain(0, 0);
      send(8'h75, 0); send(8'h0A, 0);
      step(0, 0, 1);
      do_reset();
      send(8'h76, 0); send(8'h0A, 0);
      drain(1, 1);
      repeat (3) step(0, 0, 1);

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule